// File: doc/BRIEF.md
# Five-Phase Multi-Cycle Processor Core

This block is a small general-purpose processor. A phase sequencer steers a datapath made of a program counter, an instruction register, a four-entry register file and an incrementing ALU. Every instruction runs through the same five one-clock phases in a fixed order: fetch, decode, operand fetch, execute and write-back. A phase that an instruction has no use for is spent as an idle clock and is never skipped. So a new instruction begins exactly every five cycles.

Code and data share one word-addressed memory. The core reaches it through a single-port synchronous bus. The memory samples the address at a clock edge and returns the read word during the following cycle. It commits a write at the edge that closes a cycle in which write enable is high. The instruction set has four operations: copy a memory word into a register, add one to a register, copy a register into memory, and stop. A stopped core raises a status output and holds still until reset.

Top module: `tiny_phase_cpu`

## Requirements
- R1: While reset is high and in the cycle after it is released, `mem_we` and `halted` are 0 and `mem_addr` equals `START_ADDR` (default 100). Reset also clears every register to zero.
- R2: The phases occur strictly in the order fetch, decode, operand fetch, execute, write-back, one clock each. Taking the cycle after reset release as cycle 0, instruction k is fetched from the address on `mem_addr` in cycle 5k. The fetch address rises by one for each instruction.
- R3: An instruction word carries the opcode in bits [15:12]: 0 stop, 1 load, 2 increment, 3 store. Bits [11:10] select the load or increment destination, or the store source. Bits [9:8] select the increment source. Bits [9:0] give the absolute address for load and store.
- R4: A load places its address on the bus during operand fetch. The word that comes back is written into the destination register at the end of execute.
- R5: An increment reads the source register in execute and writes source + 1, wrapping modulo 2^DATA_W, into the destination register at the end of write-back.
- R6: A store raises `mem_we` for exactly one cycle, the write-back phase (cycle 5k+4 for instruction k). In that cycle `mem_addr` carries the instruction's address and `mem_wdata` carries the source register.
- R7: Opcode 0 stops the sequencer after decode. `halted` goes to 1 at the end of the stop instruction's decode cycle, so it is first seen in cycle 5k+2. From then on no fetch and no write happens until reset.
- R8: Any opcode other than 1, 2 or 3 behaves exactly like opcode 0.
- R9: Running load R0 from 500, increment R1 from R0, store R1 to 501, starting at address 100 with 10 at address 500, leaves 11 at address 501. The fetch addresses are 100, 101 and 102.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_rdata | input | DATA_W | Read word, valid the cycle after its address was presented |
| mem_addr | output | ADDR_W | Registered word address |
| mem_wdata | output | DATA_W | Registered write data |
| mem_we | output | 1 | Registered write enable |
| halted | output | 1 | Core has stopped, sticky until reset |

## Verification
On every cycle, the embedded assertions check four things. Phase legality covers both the order and the sticky stop state. The program counter must step on each fetch. Write enable must appear only in write-back, last a single cycle and stay low once stopped. A register write must land at the selected index. The bench scenarios are the only place that shows the values that matter. These include the data that loads bring in and increments produce, including the wrap from all-ones to zero. They also cover the exact cycle in which `halted` rises and the end state of memory after whole programs. Reset clearing the registers, and unknown opcodes stopping the core, are shown there as well.

// File: rtl/tpc_pkg.sv
package tpc_pkg;

  typedef enum logic [2:0] {
    PH_FETCH   = 3'd0,
    PH_DECODE  = 3'd1,
    PH_OPFETCH = 3'd2,
    PH_EXEC    = 3'd3,
    PH_WRITE   = 3'd4,
    PH_STOP    = 3'd5
  } phase_e;

  localparam logic [3:0] OP_HALT  = 4'd0;
  localparam logic [3:0] OP_LOAD  = 4'd1;
  localparam logic [3:0] OP_INC   = 4'd2;
  localparam logic [3:0] OP_STORE = 4'd3;

  localparam int INSN_W  = 16;
  localparam int RSEL_W  = 2;
  localparam int FADDR_W = 10;

  typedef struct packed {
    logic [3:0]        op;
    logic [RSEL_W-1:0] ra;
    logic [RSEL_W-1:0] rb;
    logic [7:0]        lo;
  } insn_t;

  // Opcodes outside the implemented set fall back to the stop behaviour.
  function automatic logic is_stop(input logic [3:0] op);
    return !(op == OP_LOAD || op == OP_INC || op == OP_STORE);
  endfunction

  function automatic logic [FADDR_W-1:0] insn_addr(input insn_t i);
    return {i.rb, i.lo};
  endfunction

endpackage

// File: rtl/tpc_sequencer.sv
module tpc_sequencer
  import tpc_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   stop_req,
  output phase_e phase
);

  phase_e phase_nx;

  always_comb begin
    phase_nx = phase;
    unique case (phase)
      PH_FETCH:   phase_nx = PH_DECODE;
      PH_DECODE:  phase_nx = stop_req ? PH_STOP : PH_OPFETCH;
      PH_OPFETCH: phase_nx = PH_EXEC;
      PH_EXEC:    phase_nx = PH_WRITE;
      PH_WRITE:   phase_nx = PH_FETCH;
      PH_STOP:    phase_nx = PH_STOP;
      default:    phase_nx = PH_STOP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_FETCH;
    else     phase <= phase_nx;
  end

  // R2: fixed phase order, one clock per phase
  p_fetch_then_decode_r2: assert property (@(posedge clk) disable iff (rst)
    phase == PH_FETCH |=> phase == PH_DECODE);
  p_decode_then_opf_r2: assert property (@(posedge clk) disable iff (rst)
    phase == PH_DECODE |=> (phase == PH_OPFETCH || phase == PH_STOP));
  p_opf_then_exec_r2: assert property (@(posedge clk) disable iff (rst)
    phase == PH_OPFETCH |=> phase == PH_EXEC);
  p_exec_then_write_r2: assert property (@(posedge clk) disable iff (rst)
    phase == PH_EXEC |=> phase == PH_WRITE);
  p_write_then_fetch_r2: assert property (@(posedge clk) disable iff (rst)
    phase == PH_WRITE |=> phase == PH_FETCH);
  // R7: the stop state is left only through reset
  p_stop_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    phase == PH_STOP |=> phase == PH_STOP);

endmodule

// File: rtl/tpc_regfile.sv
module tpc_regfile #(
  parameter int DATA_W = 16,
  parameter int NREGS  = 4,
  localparam int SEL_W = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [SEL_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [SEL_W-1:0]  raddr_a,
  input  logic [SEL_W-1:0]  raddr_b,
  output logic [DATA_W-1:0] rdata_a,
  output logic [DATA_W-1:0] rdata_b
);

  logic [DATA_W-1:0] cells [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_cell
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)                               q <= '0;
      else if (we && waddr == SEL_W'(g))     q <= wdata;
    end
    assign cells[g] = q;
  end

  assign rdata_a = cells[raddr_a];
  assign rdata_b = cells[raddr_b];

  // R4/R5: a write lands in the selected register by the next cycle
  p_write_lands_r4: assert property (@(posedge clk) disable iff (rst)
    we |=> cells[$past(waddr)] == $past(wdata));

endmodule

// File: rtl/tpc_alu.sv
module tpc_alu #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] a,
  output logic [DATA_W-1:0] y
);

  // Increment wraps naturally at the data width.
  always_comb y = a + DATA_W'(1);

endmodule

// File: rtl/tiny_phase_cpu.sv
module tiny_phase_cpu
  import tpc_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int ADDR_W     = 10,
  parameter int NREGS      = 4,
  parameter int START_ADDR = 100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              halted
);

  localparam logic [ADDR_W-1:0] START = ADDR_W'(START_ADDR);

  phase_e            phase;
  logic [ADDR_W-1:0] pc;
  insn_t             ir;
  insn_t             dec;
  logic              stop_req;
  logic [DATA_W-1:0] alu_q;
  logic [DATA_W-1:0] alu_y;
  logic [DATA_W-1:0] rf_a;
  logic [DATA_W-1:0] rf_b;
  logic              rf_we;
  logic [DATA_W-1:0] rf_wdata;

  // In decode the memory's output register holds the fetched word.
  assign dec      = insn_t'(mem_rdata[INSN_W-1:0]);
  assign stop_req = (phase == PH_DECODE) && is_stop(dec.op);

  tpc_sequencer u_seq (
    .clk      (clk),
    .rst      (rst),
    .stop_req (stop_req),
    .phase    (phase)
  );

  // Load writes back at the end of execute, increment at the end of write-back.
  assign rf_we    = (phase == PH_EXEC  && ir.op == OP_LOAD) ||
                    (phase == PH_WRITE && ir.op == OP_INC);
  assign rf_wdata = (phase == PH_EXEC) ? mem_rdata : alu_q;

  tpc_regfile #(.DATA_W(DATA_W), .NREGS(NREGS)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .we      (rf_we),
    .waddr   (ir.ra),
    .wdata   (rf_wdata),
    .raddr_a (ir.ra),
    .raddr_b (ir.rb),
    .rdata_a (rf_a),
    .rdata_b (rf_b)
  );

  tpc_alu #(.DATA_W(DATA_W)) u_alu (
    .a (rf_b),
    .y (alu_y)
  );

  // Bus outputs are registered: each is set at the edge entering its phase.
  always_ff @(posedge clk) begin
    if (rst) begin
      pc        <= START;
      ir        <= '0;
      alu_q     <= '0;
      mem_addr  <= START;
      mem_wdata <= '0;
      mem_we    <= 1'b0;
      halted    <= 1'b0;
    end else begin
      unique case (phase)
        PH_FETCH: begin
          pc <= pc + ADDR_W'(1);
        end
        PH_DECODE: begin
          ir <= dec;
          if (stop_req)             halted   <= 1'b1;
          else if (dec.op == OP_LOAD) mem_addr <= ADDR_W'(insn_addr(dec));
        end
        PH_OPFETCH: ;
        PH_EXEC: begin
          alu_q <= alu_y;
          if (ir.op == OP_STORE) begin
            mem_addr  <= ADDR_W'(insn_addr(ir));
            mem_wdata <= rf_a;
            mem_we    <= 1'b1;
          end
        end
        PH_WRITE: begin
          mem_we   <= 1'b0;
          mem_addr <= pc;
        end
        default: ;
      endcase
    end
  end

  // R2: the program counter advances by one at every fetch
  p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
    phase == PH_FETCH |=> pc == $past(pc) + ADDR_W'(1));
  // R6: write enable only in write-back and for a single cycle
  p_we_in_write_r6: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> phase == PH_WRITE);
  p_we_single_r6: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);
  // R7: a stopped core never writes and stays stopped
  p_halted_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    halted |-> (!mem_we && phase == PH_STOP));
  p_halted_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

endmodule

// File: tb/tb_tiny_phase_cpu.sv
module tb_tiny_phase_cpu;

  localparam int DW = 16;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] mem_rdata;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_we;
  logic          halted;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  tiny_phase_cpu dut (
    .clk       (clk),
    .rst       (rst),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .halted    (halted)
  );

  // Memory model with a loading port used only while the core is in reset.
  logic [DW-1:0] mem [1024];
  logic          ld_en  = 1'b0;
  logic          clr_en = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [DW-1:0] ld_data = '0;

  always @(posedge clk) begin
    if (clr_en) begin
      for (int i = 0; i < 1024; i++) mem[i] <= '0;
    end else if (ld_en) begin
      mem[ld_addr] <= ld_data;
    end else if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
    end
    mem_rdata <= mem[mem_addr];
  end

  // Cycle index: number of rising edges since reset was released.
  int cnt = 0;
  always @(posedge clk) begin
    if (rst) cnt <= 0;
    else     cnt <= cnt + 1;
  end

  // Bus monitor
  logic [AW-1:0] flog [16];
  int            wr_n = 0;
  int            wcyc [8];
  logic [AW-1:0] wadr [8];
  logic [DW-1:0] wdat [8];
  always @(negedge clk) begin
    if (rst) begin
      wr_n = 0;
    end else begin
      if (cnt % 5 == 0 && cnt / 5 < 16) flog[cnt/5] = mem_addr;
      if (mem_we) begin
        if (wr_n < 8) begin
          wcyc[wr_n] = cnt;
          wadr[wr_n] = mem_addr;
          wdat[wr_n] = mem_wdata;
        end
        wr_n = wr_n + 1;
      end
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic poke(input int a, input logic [DW-1:0] d);
    ld_addr = AW'(a);
    ld_data = d;
    ld_en   = 1'b1;
    @(negedge clk);
    ld_en   = 1'b0;
  endtask

  task automatic enter_reset();
    @(negedge clk);
    rst    = 1'b1;
    clr_en = 1'b1;
    @(negedge clk);
    clr_en = 1'b0;
  endtask

  task automatic leave_reset();
    @(negedge clk);
    rst = 1'b0;   // cnt == 0 at this point
  endtask

  task automatic run_to(input int c);
    while (cnt < c) @(negedge clk);
  endtask

  // R1: outputs while reset is held and in cycle 0
  task automatic t_reset_state();
    enter_reset();
    chk("R1", "mem_we in reset", 32'(mem_we), 0);
    chk("R1", "halted in reset", 32'(halted), 0);
    chk("R1", "mem_addr in reset", 32'(mem_addr), 100);
    leave_reset();
    chk("R1", "mem_addr cycle 0", 32'(mem_addr), 100);
    chk("R1", "mem_we cycle 0", 32'(mem_we), 0);
  endtask

  // R9, R2, R3, R4, R5, R6, R7: the reference three-instruction program
  task automatic t_basic_program();
    enter_reset();
    poke(100, 16'h11F4);  // load  r0 <- [500]
    poke(101, 16'h2400);  // inc   r1 <- r0 + 1
    poke(102, 16'h35F5);  // store [501] <- r1
    poke(103, 16'h0000);  // stop
    poke(500, 16'd10);
    leave_reset();
    run_to(16);
    chk("R7", "halted before stop decode ends", 32'(halted), 0);
    run_to(17);
    chk("R7", "halted after stop decode", 32'(halted), 1);
    chk("R2", "fetch addr 0", 32'(flog[0]), 100);
    chk("R2", "fetch addr 1", 32'(flog[1]), 101);
    chk("R2", "fetch addr 2", 32'(flog[2]), 102);
    chk("R2", "fetch addr 3", 32'(flog[3]), 103);
    chk("R6", "write count", 32'(wr_n), 1);
    chk("R6", "write cycle", 32'(wcyc[0]), 14);
    chk("R6", "write address", 32'(wadr[0]), 501);
    chk("R5", "write data", 32'(wdat[0]), 11);
    chk("R9", "mem[501]", 32'(mem[501]), 11);
    chk("R4", "mem[500] unchanged", 32'(mem[500]), 10);
  endtask

  // R5 wrap, R4, R1 cleared registers (r0 was 10 before this reset)
  task automatic t_wrap_and_clear();
    enter_reset();
    poke(100, 16'h1A58);  // load  r2 <- [600]
    poke(101, 16'h2E00);  // inc   r3 <- r2 + 1
    poke(102, 16'h3E59);  // store [601] <- r3
    poke(103, 16'h3A5A);  // store [602] <- r2
    poke(104, 16'h325B);  // store [603] <- r0
    poke(105, 16'h0000);  // stop
    poke(600, 16'hFFFF);
    poke(601, 16'h1234);
    poke(603, 16'h7777);
    leave_reset();
    run_to(26);
    chk("R7", "halted before cycle 27", 32'(halted), 0);
    run_to(27);
    chk("R7", "halted at cycle 27", 32'(halted), 1);
    chk("R5", "wrapped increment", 32'(mem[601]), 0);
    chk("R4", "loaded all-ones", 32'(mem[602]), 32'hFFFF);
    chk("R1", "reset-cleared r0", 32'(mem[603]), 0);
    chk("R6", "write count", 32'(wr_n), 3);
    chk("R6", "second write cycle", 32'(wcyc[1]), 19);
    chk("R6", "third write cycle", 32'(wcyc[2]), 24);
    chk("R2", "fetch addr 5", 32'(flog[5]), 105);
  endtask

  // R8 unknown opcode stops; R7 nothing happens afterwards
  task automatic t_unknown_opcode();
    enter_reset();
    poke(100, 16'h32BC);  // store [700] <- r0
    poke(101, 16'hF3C0);  // unknown opcode
    poke(102, 16'h32BD);  // store [701] <- r0, must not run
    poke(700, 16'h5555);
    poke(701, 16'h5555);
    leave_reset();
    run_to(6);
    chk("R8", "halted before cycle 7", 32'(halted), 0);
    run_to(7);
    chk("R8", "halted at cycle 7", 32'(halted), 1);
    run_to(60);
    chk("R7", "still halted", 32'(halted), 1);
    chk("R7", "no write after stop", 32'(wr_n), 1);
    chk("R8", "first store done", 32'(mem[700]), 0);
    chk("R8", "later store skipped", 32'(mem[701]), 32'h5555);
    chk("R3", "stopped fetch address", 32'(mem_addr), 101);
  endtask

  initial begin
    t_reset_state();
    t_basic_program();
    t_wrap_and_clear();
    t_unknown_opcode();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule